// File: doc/BRIEF.md
# Shift-Register Video Timing Generator

This block produces the horizontal sync, vertical sync and display-enable strobes for a raster video output, together with the binary column and row of the pixel being shown. Its horizontal and vertical position counters are 16-bit Fibonacci shift registers, not binary adders. Each counter therefore advances through a single XOR gate, and no carry chain lies in its path. Every programmed event position is given to the block as the shift-register state that the counter reaches at that position. Binary counts are not accepted there.

Software or a mode-setting engine converts each wanted count N into "the state N steps after all-ones" and loads it into the block. The event positions are display start and stop, line or frame end, and sync on and off, each on both axes. The active width and height are the one exception: they are loaded as plain binary numbers. A pixel-clock enable paces the counters. A power-down input blanks all the strobes and parks both counters on their seed.

Top module: `lvt_timing_gen`

## Requirements
- R1: After reset both counters sit at their seed, all-ones, which is count 0. In that first pixel period hsync is low, display enable is low, both coordinates are 0, and vsync is high whenever its off count is above 0.
- R2: A counter step shifts the 16-bit state one place toward the MSB. The new bit 0 is the XOR of old bits 15, 4, 2 and 1. Every position input holds the state reached N steps after 0xFFFF, where N is the count that input stands for.
- R3: On an enabled pixel period in which the horizontal state equals `h_line_last`, the horizontal counter reloads to 0xFFFF and the vertical counter takes one step. A line therefore lasts (line-end count + 1) enabled periods.
- R4: When the horizontal counter wraps and the vertical state equals `v_frame_last`, the vertical counter reloads to 0xFFFF. A frame therefore lasts (frame-end count + 1) lines.
- R5: hsync is high for horizontal counts from the `h_sync_on` count up to, but not including, the `h_sync_off` count.
- R6: vsync is high for vertical counts from the `v_sync_on` count up to, but not including, the `v_sync_off` count.
- R7: disp_en is high exactly when the horizontal count lies in the half-open window [`h_act_start` count, `h_act_stop` count) and the vertical count lies in [`v_act_start` count, `v_act_stop` count).
- R8: While disp_en is high, pix_x equals the horizontal count minus the horizontal display-start count, and pix_y equals the vertical count minus the vertical display-start count. While disp_en is low both are 0.
- R9: The binary limits `h_active_px` and `v_active_ln` cap pix_x at h_active_px−1 and pix_y at v_active_ln−1. A coordinate that reaches its cap holds there for the rest of the window.
- R10: In a clock cycle with pix_ce low, neither counter, no window and neither coordinate changes, so all outputs hold their values.
- R11: While pwr_down is high, hsync, vsync, disp_en, pix_x and pix_y are all 0 and both counters are held at 0xFFFF. After pwr_down is released, output resumes from count 0 on both axes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pix_ce | input | 1 | Pixel-period enable; one counter step per high cycle |
| pwr_down | input | 1 | Blank all outputs and park counters at seed |
| h_act_start | input | 16 | Horizontal display start, shift-register state |
| h_act_stop | input | 16 | Horizontal display stop, shift-register state |
| h_line_last | input | 16 | Last horizontal count of a line, shift-register state |
| h_sync_on | input | 16 | Horizontal sync assert position, shift-register state |
| h_sync_off | input | 16 | Horizontal sync release position, shift-register state |
| v_act_start | input | 16 | Vertical display start, shift-register state |
| v_act_stop | input | 16 | Vertical display stop, shift-register state |
| v_frame_last | input | 16 | Last vertical count of a frame, shift-register state |
| v_sync_on | input | 16 | Vertical sync assert position, shift-register state |
| v_sync_off | input | 16 | Vertical sync release position, shift-register state |
| h_active_px | input | 12 | Active width, binary |
| v_active_ln | input | 12 | Active height, binary |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| disp_en | output | 1 | Display enable |
| pix_x | output | 12 | Binary column of the current active pixel |
| pix_y | output | 12 | Binary row of the current active pixel |

## Verification
Suppose a counter steps with the wrong feedback tap or misses its reload. The programmed states then stop matching at the expected counts, and hsync or disp_en is wrong within the same line, usually at the first edge after the fault. A vertical fault shows at the next line boundary as a wrong vsync or pix_y.

A window flag stuck set or clear shows as a strobe that lasts a period too long or too short at its edge. A coordinate counter that fails to clear or saturate shows in the first active pixel of the next line. The bench compares every output on every pixel period against a count-based model. It covers a compact mode, a 640-wide line, a gated enable, a power-down interval and clamped width and height.

// File: rtl/lvt_pkg.sv
// Package: constants shared by the shift-register timing generator.
// Assumes a 16-bit Fibonacci register with feedback taps 15, 4, 2 and 1.
package lvt_pkg;
    localparam int          LFSR_W    = 16;
    localparam logic [15:0] LFSR_SEED = 16'hFFFF;
    // Tap mask: bits 15, 4, 2, 1 feed the XOR for the new bit 0
    localparam logic [15:0] LFSR_TAPS = 16'h8016;
    localparam int          PIX_W     = 12;
    localparam int          NUM_WIN   = 4;
endpackage

// File: rtl/lvt_lfsr_ctr.sv
// Position counter built from a Fibonacci shift register.
// Each enabled step shifts toward the MSB and inserts the XOR of the tapped
// bits at bit 0. On a step taken while the state equals wrap_val it reloads
// to SEED instead. park holds it at SEED. Assumes wrap_val is reachable.
module lvt_lfsr_ctr #(
    parameter int             W    = 16,
    parameter logic [W-1:0]   SEED = '1,
    parameter logic [W-1:0]   TAPS = 16'h8016
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          park,
    input  logic          step,
    input  logic [W-1:0]  wrap_val,
    output logic [W-1:0]  state,
    output logic          at_wrap
);
    logic [W-1:0] nxt;

    // Comparator against the programmed end state
    assign at_wrap = (state == wrap_val);

    // Next state of the shift register
    assign nxt = {state[W-2:0], ^(state & TAPS)};

    // Counter register: seed on reset or park, reload on wrap, else shift
    always_ff @(posedge clk) begin
        if (!rst_n || park) begin
            state <= SEED;
        end else if (step) begin
            state <= at_wrap ? SEED : nxt;
        end
    end
endmodule

// File: rtl/lvt_window.sv
// Half-open window decoder on a counter state. win is high from the state
// equal to on_val up to, but not including, the state equal to off_val.
// A flag carries the window across states between the two matches and is
// updated once per counter step (adv). Assumes on_val and off_val differ.
module lvt_window #(
    parameter int W = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          park,
    input  logic          adv,
    input  logic [W-1:0]  state,
    input  logic [W-1:0]  on_val,
    input  logic [W-1:0]  off_val,
    output logic          win
);
    logic flag_q;
    logic hit_on;
    logic hit_off;

    // Matches on the current counter state
    assign hit_on  = (state == on_val);
    assign hit_off = (state == off_val);

    // Window value for the present count
    assign win = !park && (hit_on || (flag_q && !hit_off));

    // Carry the window into the next count
    always_ff @(posedge clk) begin
        if (!rst_n || park) begin
            flag_q <= 1'b0;
        end else if (adv) begin
            flag_q <= win;
        end
    end
endmodule

// File: rtl/lvt_bin_ctr.sv
// Binary coordinate counter. On each adv it clears while run is low and
// otherwise counts up, holding at lim-1. Assumes lim is at least 1 when used.
module lvt_bin_ctr #(
    parameter int W = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          park,
    input  logic          adv,
    input  logic          run,
    input  logic [W-1:0]  lim,
    output logic [W-1:0]  val
);
    logic [W:0] inc;

    // Incremented value with a spare bit for the limit compare
    assign inc = {1'b0, val} + {{W{1'b0}}, 1'b1};

    // Coordinate register: clear outside the window, saturate at the limit
    always_ff @(posedge clk) begin
        if (!rst_n || park) begin
            val <= '0;
        end else if (adv) begin
            if (!run) begin
                val <= '0;
            end else if (inc < {1'b0, lim}) begin
                val <= inc[W-1:0];
            end
        end
    end
endmodule

// File: rtl/lvt_timing_gen.sv
// Top of the shift-register video timing generator.
// The horizontal counter steps on every pix_ce and wraps on h_line_last.
// The vertical counter steps on each horizontal wrap and wraps on
// v_frame_last. Four window decoders produce the display-enable and sync
// strobes for the two axes. Two binary counters give the pixel coordinates.
// Assumes all position inputs are shift-register states and are held
// stable while the generator runs.
module lvt_timing_gen #(
    parameter int LW = lvt_pkg::LFSR_W,
    parameter int PW = lvt_pkg::PIX_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           pix_ce,
    input  logic           pwr_down,
    input  logic [LW-1:0]  h_act_start,
    input  logic [LW-1:0]  h_act_stop,
    input  logic [LW-1:0]  h_line_last,
    input  logic [LW-1:0]  h_sync_on,
    input  logic [LW-1:0]  h_sync_off,
    input  logic [LW-1:0]  v_act_start,
    input  logic [LW-1:0]  v_act_stop,
    input  logic [LW-1:0]  v_frame_last,
    input  logic [LW-1:0]  v_sync_on,
    input  logic [LW-1:0]  v_sync_off,
    input  logic [PW-1:0]  h_active_px,
    input  logic [PW-1:0]  v_active_ln,
    output logic           hsync,
    output logic           vsync,
    output logic           disp_en,
    output logic [PW-1:0]  pix_x,
    output logic [PW-1:0]  pix_y
);
    localparam int NW = lvt_pkg::NUM_WIN;
    localparam int IX_HDE = 0;
    localparam int IX_HS  = 1;
    localparam int IX_VDE = 2;
    localparam int IX_VS  = 3;

    logic [LW-1:0] h_state;
    logic [LW-1:0] v_state;
    logic          h_wrap;
    logic          v_wrap;
    logic          v_step;
    logic [PW-1:0] x_q;
    logic [PW-1:0] y_q;

    logic [LW-1:0] w_state [NW];
    logic [LW-1:0] w_on    [NW];
    logic [LW-1:0] w_off   [NW];
    logic          w_adv   [NW];
    logic          w_out   [NW];

    // Vertical advances once per completed line
    assign v_step = pix_ce && h_wrap;

    lvt_lfsr_ctr #(
        .W(LW), .SEED(lvt_pkg::LFSR_SEED), .TAPS(lvt_pkg::LFSR_TAPS)
    ) u_hctr (
        .clk(clk), .rst_n(rst_n), .park(pwr_down), .step(pix_ce),
        .wrap_val(h_line_last), .state(h_state), .at_wrap(h_wrap)
    );

    lvt_lfsr_ctr #(
        .W(LW), .SEED(lvt_pkg::LFSR_SEED), .TAPS(lvt_pkg::LFSR_TAPS)
    ) u_vctr (
        .clk(clk), .rst_n(rst_n), .park(pwr_down), .step(v_step),
        .wrap_val(v_frame_last), .state(v_state), .at_wrap(v_wrap)
    );

    // Route counter, bounds and step strobe to each window decoder
    always_comb begin
        w_state[IX_HDE] = h_state;     w_adv[IX_HDE] = pix_ce;
        w_on[IX_HDE]    = h_act_start; w_off[IX_HDE] = h_act_stop;
        w_state[IX_HS]  = h_state;     w_adv[IX_HS]  = pix_ce;
        w_on[IX_HS]     = h_sync_on;   w_off[IX_HS]  = h_sync_off;
        w_state[IX_VDE] = v_state;     w_adv[IX_VDE] = v_step;
        w_on[IX_VDE]    = v_act_start; w_off[IX_VDE] = v_act_stop;
        w_state[IX_VS]  = v_state;     w_adv[IX_VS]  = v_step;
        w_on[IX_VS]     = v_sync_on;   w_off[IX_VS]  = v_sync_off;
    end

    for (genvar g = 0; g < NW; g++) begin : g_win
        lvt_window #(.W(LW)) u_win (
            .clk(clk), .rst_n(rst_n), .park(pwr_down), .adv(w_adv[g]),
            .state(w_state[g]), .on_val(w_on[g]), .off_val(w_off[g]),
            .win(w_out[g])
        );
    end

    lvt_bin_ctr #(.W(PW)) u_xctr (
        .clk(clk), .rst_n(rst_n), .park(pwr_down), .adv(pix_ce),
        .run(w_out[IX_HDE]), .lim(h_active_px), .val(x_q)
    );

    lvt_bin_ctr #(.W(PW)) u_yctr (
        .clk(clk), .rst_n(rst_n), .park(pwr_down), .adv(v_step),
        .run(w_out[IX_VDE]), .lim(v_active_ln), .val(y_q)
    );

    // Output strobes and coordinates gated by the display window
    assign hsync   = w_out[IX_HS];
    assign vsync   = w_out[IX_VS];
    assign disp_en = w_out[IX_HDE] && w_out[IX_VDE];
    assign pix_x   = disp_en ? x_q : '0;
    assign pix_y   = disp_en ? y_q : '0;
endmodule

// File: rtl/lvt_timing_chk.sv
// Checker for lvt_timing_gen: counter wrap, hold and power-down rules
// and coordinate bounds. Attached to every instance through bind.
module lvt_timing_chk #(
    parameter int LW = 16,
    parameter int PW = 12
) (
    input logic           clk,
    input logic           rst_n,
    input logic           pix_ce,
    input logic           pwr_down,
    input logic [LW-1:0]  h_line_last,
    input logic [LW-1:0]  v_frame_last,
    input logic [PW-1:0]  h_active_px,
    input logic [PW-1:0]  v_active_ln,
    input logic           hsync,
    input logic           vsync,
    input logic           disp_en,
    input logic [PW-1:0]  pix_x,
    input logic [PW-1:0]  pix_y,
    input logic [LW-1:0]  h_state,
    input logic [LW-1:0]  v_state
);
    localparam logic [LW-1:0] SEED = '1;

    a_r3_line_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_ce && !pwr_down && h_state == h_line_last) |=> (h_state == SEED));

    a_r3_v_hold_midline: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwr_down && !(pix_ce && h_state == h_line_last)) |=> $stable(v_state));

    a_r4_frame_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_ce && !pwr_down && h_state == h_line_last && v_state == v_frame_last)
        |=> (v_state == SEED));

    a_r10_ce_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!pix_ce && !pwr_down) |=> ($stable(h_state) && $stable(v_state)));

    a_r11_pd_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down |-> (!hsync && !vsync && !disp_en));

    a_r11_pd_seed: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down |=> (h_state == SEED && v_state == SEED));

    a_r8_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !disp_en |-> (pix_x == '0 && pix_y == '0));

    a_r9_x_cap: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_en && h_active_px != '0) |-> (pix_x < h_active_px));

    a_r9_y_cap: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_en && v_active_ln != '0) |-> (pix_y < v_active_ln));
endmodule

bind lvt_timing_gen lvt_timing_chk #(.LW(LW), .PW(PW)) u_chk (
    .clk(clk), .rst_n(rst_n), .pix_ce(pix_ce), .pwr_down(pwr_down),
    .h_line_last(h_line_last), .v_frame_last(v_frame_last),
    .h_active_px(h_active_px), .v_active_ln(v_active_ln),
    .hsync(hsync), .vsync(vsync), .disp_en(disp_en),
    .pix_x(pix_x), .pix_y(pix_y), .h_state(h_state), .v_state(v_state)
);

// File: tb/lvt_timing_gen_bench.sv
// Scoreboard bench: the driver advances a count-based model, pushes the
// expected outputs and signals the monitor, which compares them.
module lvt_timing_gen_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pix_ce = 1'b0;
    logic        pwr_down = 1'b0;
    logic [15:0] h_act_start, h_act_stop, h_line_last, h_sync_on, h_sync_off;
    logic [15:0] v_act_start, v_act_stop, v_frame_last, v_sync_on, v_sync_off;
    logic [11:0] h_active_px, v_active_ln;
    logic        hsync, vsync, disp_en;
    logic [11:0] pix_x, pix_y;

    always #10 clk = ~clk;

    lvt_timing_gen u_lvt_timing_gen (
        .clk(clk), .rst_n(rst_n), .pix_ce(pix_ce), .pwr_down(pwr_down),
        .h_act_start(h_act_start), .h_act_stop(h_act_stop),
        .h_line_last(h_line_last), .h_sync_on(h_sync_on),
        .h_sync_off(h_sync_off), .v_act_start(v_act_start),
        .v_act_stop(v_act_stop), .v_frame_last(v_frame_last),
        .v_sync_on(v_sync_on), .v_sync_off(v_sync_off),
        .h_active_px(h_active_px), .v_active_ln(v_active_ln),
        .hsync(hsync), .vsync(vsync), .disp_en(disp_en),
        .pix_x(pix_x), .pix_y(pix_y)
    );

    typedef struct {
        logic  hs;
        logic  vs;
        logic  de;
        int    x;
        int    y;
        string tag;
    } exp_t;

    exp_t q[$];
    event ev_chk;
    int   n_chk = 0;
    int   n_bad = 0;
    int   cyc = 0;
    bit   done = 1'b0;

    // Timing in counts
    int c_hds, c_hde, c_hl, c_hso, c_vds, c_vde, c_vf, c_vso, c_wa, c_ha;
    // Model position and power-down state
    int m_h = 0;
    int m_v = 0;
    bit m_pd = 1'b0;

    // R2: state reached n steps after all-ones
    function automatic logic [15:0] enc(input int n);
        logic [15:0] s;
        s = 16'hFFFF;
        for (int i = 0; i < n; i++) s = {s[14:0], s[15] ^ s[4] ^ s[2] ^ s[1]};
        return s;
    endfunction

    // Program a mode from its display, sync and total sizes
    task automatic set_mode(input int hd, hss, hse, ht, vd, vss, vse, vt, wa, ha);
        c_hds = ht - hss; c_hde = c_hds + hd; c_hl = ht - 1; c_hso = hse - hss + 1;
        c_vds = vt - vss; c_vde = c_vds + vd; c_vf = vt;     c_vso = vse - vss;
        c_wa = wa; c_ha = ha;
        h_act_start = enc(c_hds); h_act_stop = enc(c_hde); h_line_last = enc(c_hl);
        h_sync_on = enc(1); h_sync_off = enc(c_hso);
        v_act_start = enc(c_vds); v_act_stop = enc(c_vde); v_frame_last = enc(c_vf);
        v_sync_on = enc(0); v_sync_off = enc(c_vso);
        h_active_px = 12'(wa); v_active_ln = 12'(ha);
    endtask

    // Expected outputs for the model position
    function automatic exp_t expect_now(input string tag);
        exp_t e;
        e.tag = tag;
        if (m_pd) begin
            e.hs = 0; e.vs = 0; e.de = 0; e.x = 0; e.y = 0;
        end else begin
            e.hs = (m_h >= 1) && (m_h < c_hso);
            e.vs = (m_v < c_vso);
            e.de = (m_h >= c_hds) && (m_h < c_hde) && (m_v >= c_vds) && (m_v < c_vde);
            e.x = e.de ? ((m_h - c_hds) < c_wa ? (m_h - c_hds) : c_wa - 1) : 0;
            e.y = e.de ? ((m_v - c_vds) < c_ha ? (m_v - c_vds) : c_ha - 1) : 0;
        end
        return e;
    endfunction

    // Push an expectation and release the monitor
    task automatic push_check(input string tag);
        q.push_back(expect_now(tag));
        -> ev_chk;
        #2;
    endtask

    // Drive one clock with the given enables and advance the model
    task automatic tick(input bit ce, input bit pd, input string tag);
        pix_ce = ce; pwr_down = pd; m_pd = pd;
        if (pd) begin
            m_h = 0; m_v = 0;
        end else if (ce) begin
            if (m_h == c_hl) begin
                m_h = 0;
                m_v = (m_v == c_vf) ? 0 : m_v + 1;
            end else begin
                m_h = m_h + 1;
            end
        end
        @(posedge clk);
        @(negedge clk);
        push_check(tag);
    endtask

    task automatic do_reset();
        rst_n = 0; pix_ce = 0; pwr_down = 0; m_pd = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1; m_h = 0; m_v = 0;
        push_check("R1");
    endtask

    task automatic cmp_bit(input string what, input string rq, input logic act, input logic ex);
        n_chk++;
        if (act !== ex) begin
            n_bad++;
            $display("FAIL %s [%s] got %0b expected %0b at h=%0d v=%0d", what, rq, act, ex, m_h, m_v);
        end
    endtask

    task automatic cmp_int(input string what, input string rq, input int act, input int ex);
        n_chk++;
        if (act != ex) begin
            n_bad++;
            $display("FAIL %s [%s] got %0d expected %0d at h=%0d v=%0d", what, rq, act, ex, m_h, m_v);
        end
    endtask

    // Monitor: pop expectations and compare against the ports
    initial begin
        forever begin
            @(ev_chk);
            while (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                cmp_bit("hsync",   {"R5 ", e.tag}, hsync,   e.hs);
                cmp_bit("vsync",   {"R6 ", e.tag}, vsync,   e.vs);
                cmp_bit("disp_en", {"R7 ", e.tag}, disp_en, e.de);
                cmp_int("pix_x",   {"R8 ", e.tag}, int'(pix_x), e.x);
                cmp_int("pix_y",   {"R8 ", e.tag}, int'(pix_y), e.y);
            end
        end
    end

    // Watchdog: a hung run counts as a failed check
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog [R3 R4] got %0d cycles expected under 150000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // Compact mode: 20-count lines, 12-line frames
        set_mode(10, 12, 14, 20, 6, 7, 9, 11, 10, 6);
        do_reset();
        // R3 R4: two full frames with continuous enable, with line and frame wraps
        for (int i = 0; i < 480; i++) tick(1, 0, "R3 R4");
        // R10: gated enable, outputs hold on low cycles
        for (int i = 0; i < 600; i++) tick((i % 3) != 0, 0, "R10");
        // R11: power-down mid-frame, then resume from count 0
        for (int i = 0; i < 40; i++) tick(1, 1, "R11");
        for (int i = 0; i < 300; i++) tick(1, 0, "R11");
        // R9: width and height clamped below the window size
        set_mode(10, 12, 14, 20, 6, 7, 9, 11, 4, 3);
        do_reset();
        for (int i = 0; i < 500; i++) tick(1, 0, "R9");
        // R2: 640-wide line with a short frame; states many steps from the seed
        set_mode(640, 656, 752, 800, 3, 4, 5, 6, 640, 3);
        do_reset();
        for (int i = 0; i < 6000; i++) tick(1, 0, "R2");
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule